// File: doc/BRIEF.md
# Output Virtual-Channel Credit and Ownership Tracker

This block holds the state of one router output port under credit-based link flow control. For every virtual channel (VC) on the outgoing link it counts the flit buffers that are still free at the next router. It also keeps a small state machine that records whether the output VC is free, or is carrying a packet for a named input VC, or has stalled because the downstream side has no room.

The switch sends a pulse for each flit it forwards, and a second bit marks that flit as a tail. The downstream node sends back one credit pulse for each flit that leaves its buffer. The VC allocator claims a free output VC for an input VC with a single request. It reads the busy flags and the owner fields to see which VCs it can still hand out. The per-VC send-enable tells the switch allocator where a flit may go.

The counter starts at the downstream depth. Because it only goes back up when a credit arrives, it also covers flits that are still on the wire and credits that have not yet returned.

Top module: `ovc_credit_tracker`

## Requirements
- R1: After reset every credit count equals BUF_DEPTH (default 4), every VC state is idle (code 0), every owner field is 0, and every send-enable and error bit is 0.
- R2: Each sent flit lowers that VC's count by one, and each credit pulse raises it by one. A send and a credit in the same cycle leave the count unchanged. All counts show on the cycle after the pulses.
- R3: An allocation request that names an idle output VC makes it active (code 1) on the next cycle and stores the requesting input VC as its owner. If that VC's count is zero, it becomes waiting-for-credit (code 2) instead.
- R4: When an active VC's count falls to zero it moves to waiting-for-credit (code 2) and its send-enable drops. The first credit that brings the count above zero returns it to active.
- R5: A sent flit marked tail puts the VC back to idle and clears its owner to 0 on the next cycle. It also takes one credit.
- R6: A credit that would raise a count above BUF_DEPTH, with no send on that VC in the same cycle, is dropped: the count stays at BUF_DEPTH and that VC's error bit is high for exactly the next cycle.
- R7: An allocation request that names a VC that is not idle is ignored: its owner and state stay the same.
- R8: Send-enable is high exactly when the VC is active, and an active VC always has a nonzero count. Pulses on one VC never change another VC's count, state or owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_req | input | 1 | Allocation request for one output VC |
| alloc_ovc | input | VC_W | Output VC being claimed |
| alloc_ivc | input | IVC_W | Input VC that claims it |
| sent_vld | input | NUM_VC | Per-VC pulse: a flit went out this cycle |
| sent_tail | input | NUM_VC | Per-VC: the flit sent is a tail |
| credit_in | input | NUM_VC | Per-VC credit return pulse |
| can_send | output | NUM_VC | Per-VC send-enable |
| vc_busy | output | NUM_VC | Per-VC: output VC is not idle |
| vc_state | output | 2*NUM_VC | Per-VC state code (0 idle, 1 active, 2 waiting) |
| vc_owner | output | IVC_W*NUM_VC | Per-VC owning input VC |
| credit_cnt | output | CNT_W*NUM_VC | Per-VC free downstream buffers |
| credit_err | output | NUM_VC | Per-VC one-cycle flag for an excess credit |

## Verification
The assertions assume that the switch never sends a flit on a VC whose send-enable is low, and that tail and body flits arrive only on active VCs. Under those conditions the count can never go below zero, and an active state always has credit. The directed tasks drive sends only after they have seen send-enable high. Allocation requests against busy VCs and excess credits are deliberate stimulus, because the block is specified to tolerate both.

// File: rtl/ovc_pkg.sv
// Shared types for the output VC tracker.
// Assumes a state code fits in two bits; the codes are visible at the ports.
package ovc_pkg;
    typedef enum logic [1:0] {
        OVC_IDLE   = 2'd0,
        OVC_ACTIVE = 2'd1,
        OVC_WAIT   = 2'd2
    } ovc_state_e;
endpackage

// File: rtl/ovc_credit_cnt.sv
// Free-buffer counter for one downstream VC.
// Starts at DEPTH. A send takes one and a credit gives one back; both together
// cancel. A credit that would exceed DEPTH is dropped and flagged one cycle later.
// Assumes the sender never sends while the count is zero (that send is ignored).
module ovc_credit_cnt #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_next_o,
    output logic          err_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic dec_ok;
    logic inc_ok;
    logic over;

    // Qualify pulses against the present count.
    always_comb begin
        dec_ok = dec_i && (cnt_o != '0);
        over   = inc_i && !dec_ok && (cnt_o == FULL);
        inc_ok = inc_i && !over;
        if (dec_ok && !inc_ok)      cnt_next_o = cnt_o - 1'b1;
        else if (inc_ok && !dec_ok) cnt_next_o = cnt_o + 1'b1;
        else                        cnt_next_o = cnt_o;
    end

    // Hold the count and the one-cycle overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= FULL;
            err_o <= 1'b0;
        end else begin
            cnt_o <= cnt_next_o;
            err_o <= over;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= FULL);
    // R2
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && cnt_o != FULL) |=> (cnt_o == $past(cnt_o) + 1'b1));
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && cnt_o == FULL) |=> (err_o && cnt_o == FULL));
endmodule

// File: rtl/ovc_fsm.sv
// Ownership state machine for one output VC: idle, active or waiting for credit.
// It uses the counter's next value, so state and count change on the same edge.
// Assumes flits are sent only while active. A tail wins over a credit stall.
module ovc_fsm #(
    parameter int CW    = 3,
    parameter int IVC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim_i,
    input  logic [IVC_W-1:0] claim_ivc_i,
    input  logic             sent_i,
    input  logic             tail_i,
    input  logic [CW-1:0]    cnt_i,
    input  logic [CW-1:0]    cnt_next_i,
    output ovc_pkg::ovc_state_e state_o,
    output logic [IVC_W-1:0] owner_o
);
    import ovc_pkg::*;

    ovc_state_e state_n;
    logic [IVC_W-1:0] owner_n;

    // Next-state and owner selection.
    always_comb begin
        state_n = state_o;
        owner_n = owner_o;
        unique case (state_o)
            OVC_IDLE: if (claim_i) begin
                owner_n = claim_ivc_i;
                state_n = (cnt_next_i == '0) ? OVC_WAIT : OVC_ACTIVE;
            end
            OVC_ACTIVE: begin
                if (sent_i && tail_i) begin
                    state_n = OVC_IDLE;
                    owner_n = '0;
                end else if (cnt_next_i == '0) begin
                    state_n = OVC_WAIT;
                end
            end
            OVC_WAIT: if (cnt_next_i != '0) state_n = OVC_ACTIVE;
            default: begin
                state_n = OVC_IDLE;
                owner_n = '0;
            end
        endcase
    end

    // Register state and owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= OVC_IDLE;
            owner_o <= '0;
        end else begin
            state_o <= state_n;
            owner_o <= owner_n;
        end
    end

    // R8
    active_has_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == OVC_ACTIVE) |-> (cnt_i != '0));
    // R5
    idle_owner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == OVC_IDLE) |-> (owner_o == '0));
    // R5
    tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == OVC_ACTIVE && sent_i && tail_i) |=> (state_o == OVC_IDLE));
    // R7
    busy_owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == OVC_WAIT) |=> $stable(owner_o));
endmodule

// File: rtl/ovc_credit_tracker.sv
// Per-output-port tracker: one credit counter and one ownership FSM per VC.
// Decodes the single allocation request to the named VC and flattens the
// per-VC status onto the ports. Assumes no flit is sent on a VC with can_send low.
module ovc_credit_tracker #(
    parameter int NUM_VC    = 4,
    parameter int NUM_IN_VC = 8,
    parameter int BUF_DEPTH = 4,
    localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int IVC_W    = (NUM_IN_VC > 1) ? $clog2(NUM_IN_VC) : 1,
    localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_req,
    input  logic [VC_W-1:0]         alloc_ovc,
    input  logic [IVC_W-1:0]        alloc_ivc,
    input  logic [NUM_VC-1:0]       sent_vld,
    input  logic [NUM_VC-1:0]       sent_tail,
    input  logic [NUM_VC-1:0]       credit_in,
    output logic [NUM_VC-1:0]       can_send,
    output logic [NUM_VC-1:0]       vc_busy,
    output logic [2*NUM_VC-1:0]     vc_state,
    output logic [IVC_W*NUM_VC-1:0] vc_owner,
    output logic [CNT_W*NUM_VC-1:0] credit_cnt,
    output logic [NUM_VC-1:0]       credit_err
);
    import ovc_pkg::*;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cnt_nx;
        logic             claim;
        ovc_state_e       st;
        logic [IVC_W-1:0] own;

        // Decode the allocation request for this VC.
        assign claim = alloc_req && (alloc_ovc == VC_W'(v));

        ovc_credit_cnt #(.DEPTH(BUF_DEPTH)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .dec_i      (sent_vld[v]),
            .inc_i      (credit_in[v]),
            .cnt_o      (cnt),
            .cnt_next_o (cnt_nx),
            .err_o      (credit_err[v])
        );

        ovc_fsm #(.CW(CNT_W), .IVC_W(IVC_W)) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .claim_i     (claim),
            .claim_ivc_i (alloc_ivc),
            .sent_i      (sent_vld[v]),
            .tail_i      (sent_tail[v]),
            .cnt_i       (cnt),
            .cnt_next_i  (cnt_nx),
            .state_o     (st),
            .owner_o     (own)
        );

        // Flatten status for the allocators.
        assign can_send[v]                  = (st == OVC_ACTIVE);
        assign vc_busy[v]                   = (st != OVC_IDLE);
        assign vc_state[2*v +: 2]           = st;
        assign vc_owner[IVC_W*v +: IVC_W]   = own;
        assign credit_cnt[CNT_W*v +: CNT_W] = cnt;

        // R4
        wait_blocks_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st == OVC_WAIT) |-> !can_send[v]);
    end
endmodule

// File: tb/sim_ovc_credit_tracker.sv
module sim_ovc_credit_tracker;
    localparam int NV = 4, NI = 8, D = 4;
    localparam int VW = 2, IW = 3, CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_req = 1'b0;
    logic [VW-1:0] alloc_ovc = '0;
    logic [IW-1:0] alloc_ivc = '0;
    logic [NV-1:0] sent_vld = '0, sent_tail = '0, credit_in = '0;
    logic [NV-1:0] can_send, vc_busy, credit_err;
    logic [2*NV-1:0] vc_state;
    logic [IW*NV-1:0] vc_owner;
    logic [CW*NV-1:0] credit_cnt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ovc_credit_tracker #(.NUM_VC(NV), .NUM_IN_VC(NI), .BUF_DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ovc(alloc_ovc),
        .alloc_ivc(alloc_ivc), .sent_vld(sent_vld), .sent_tail(sent_tail),
        .credit_in(credit_in), .can_send(can_send), .vc_busy(vc_busy),
        .vc_state(vc_state), .vc_owner(vc_owner), .credit_cnt(credit_cnt),
        .credit_err(credit_err)
    );

    function automatic int cnt_of(int v);  return int'(credit_cnt[CW*v +: CW]); endfunction
    function automatic int st_of(int v);   return int'(vc_state[2*v +: 2]);     endfunction
    function automatic int own_of(int v);  return int'(vc_owner[IW*v +: IW]);   endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock, then settle past the edge before sampling; clear pulses.
    task automatic step();
        @(posedge clk);
        #2;
        alloc_req = 1'b0; sent_vld = '0; sent_tail = '0; credit_in = '0;
    endtask

    task automatic t_reset();
        for (int v = 0; v < NV; v++) begin
            chk("R1", "count", cnt_of(v), D);
            chk("R1", "state", st_of(v), 0);
            chk("R1", "owner", own_of(v), 0);
        end
        chk("R1", "can_send", int'(can_send), 0);
        chk("R1", "err", int'(credit_err), 0);
    endtask

    task automatic t_alloc();
        alloc_req = 1'b1; alloc_ovc = 2'd0; alloc_ivc = 3'd5;
        step();
        chk("R3", "state vc0", st_of(0), 1);
        chk("R3", "owner vc0", own_of(0), 5);
        chk("R8", "can_send vc0", int'(can_send[0]), 1);
        chk("R8", "vc1 untouched", st_of(1), 0);
    endtask

    task automatic t_drain();
        for (int i = 0; i < 3; i++) begin
            sent_vld[0] = 1'b1;
            step();
        end
        chk("R2", "count after 3 sends", cnt_of(0), 1);
        chk("R4", "still active", st_of(0), 1);
        sent_vld[0] = 1'b1;
        step();
        chk("R2", "count after 4 sends", cnt_of(0), 0);
        chk("R4", "waiting", st_of(0), 2);
        chk("R4", "can_send low", int'(can_send[0]), 0);
        chk("R8", "vc1 count untouched", cnt_of(1), D);
        credit_in[0] = 1'b1;
        step();
        chk("R4", "resume active", st_of(0), 1);
        chk("R2", "count after credit", cnt_of(0), 1);
    endtask

    task automatic t_simul();
        sent_vld[0] = 1'b1; credit_in[0] = 1'b1;
        step();
        chk("R2", "send+credit count", cnt_of(0), 1);
        chk("R2", "send+credit state", st_of(0), 1);
    endtask

    task automatic t_busy_alloc();
        alloc_req = 1'b1; alloc_ovc = 2'd0; alloc_ivc = 3'd3;
        step();
        chk("R7", "owner kept", own_of(0), 5);
        chk("R7", "state kept", st_of(0), 1);
    endtask

    task automatic t_tail();
        sent_vld[0] = 1'b1; sent_tail[0] = 1'b1;
        step();
        chk("R5", "idle after tail", st_of(0), 0);
        chk("R5", "owner cleared", own_of(0), 0);
        chk("R5", "tail took credit", cnt_of(0), 0);
    endtask

    task automatic t_alloc_zero();
        alloc_req = 1'b1; alloc_ovc = 2'd0; alloc_ivc = 3'd2;
        step();
        chk("R3", "alloc at zero waits", st_of(0), 2);
        chk("R3", "owner at zero", own_of(0), 2);
        chk("R8", "no send at zero", int'(can_send[0]), 0);
        credit_in[0] = 1'b1;
        step();
        chk("R4", "first credit activates", st_of(0), 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 3; i++) begin
            credit_in[0] = 1'b1;
            step();
        end
        chk("R2", "refilled", cnt_of(0), D);
        chk("R6", "no err yet", int'(credit_err[0]), 0);
        credit_in[0] = 1'b1; credit_in[3] = 1'b1;
        step();
        chk("R6", "count held vc0", cnt_of(0), D);
        chk("R6", "err vc0", int'(credit_err[0]), 1);
        chk("R6", "err vc3", int'(credit_err[3]), 1);
        chk("R8", "err vc1 clear", int'(credit_err[1]), 0);
        step();
        chk("R6", "err one cycle", int'(credit_err), 0);
        chk("R6", "count held vc3", cnt_of(3), D);
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_alloc();
        t_drain();
        t_simul();
        t_busy_alloc();
        t_tail();
        t_alloc_zero();
        t_overflow();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule